// File: doc/BRIEF.md
# Monitoring ADC Enable and Conversion Sequencer

This block is the control side of a housekeeping ADC in a power-management device. The host writes one configuration word: a run bit, a single/repeat mode bit, a temperature-channel select and an interrupt mask. The block keeps the run bit only while the supply conditions allow conversion. It drives one-cycle start strobes to the converter and takes its completion strobes back. It reports single-conversion completion through a live status bit, a sticky flag and a maskable interrupt pulse.

Three comparator inputs feed the supply check: input supply above its poor-source level, battery above its low level, and battery above the level needed to start the internal regulator. With input power present, conversion is always allowed. On battery alone, the low-battery level is enough when the temperature channel is off. When the temperature channel is on, the battery must also be above the regulator level.

The sequencer has three states. `ST_IDLE` waits for the run bit. `ST_LAUNCH` drives the start strobe. `ST_CONVERT` waits for the completion strobe. The transitions are:

- Idle to launch: the run bit is set and the supply is valid.
- Launch to convert: the strobe is issued.
- Convert to launch: a completion arrives in repeat mode.
- Convert to idle: a completion arrives in single mode.
- Launch or convert to idle: the run bit or supply validity is lost. This is an abort.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `run_en`, `mode_single`, `temp_sel`, `irq_mask`, `done_stat`, `done_flag`, `irq` and `conv_start` are all 0.
- R2: On a `cfg_we` cycle, `run_en` takes `cfg_run & valid`. Here `valid = vbus_ok | (temp ? vbat_regn_ok : vbat_ok)`, where `temp` is the `cfg_temp` value written in that same cycle. A rejected write reads back 0 in the next cycle.
- R3: With the temperature channel selected and `vbus_ok` low, `vbat_ok` alone does not make `valid` true; `vbat_regn_ok` is needed.
- R4: When `valid` goes low, `run_en` clears at the next edge. In the same cycle `conv_start` is forced low, the sequence returns to idle, and a completion that follows is ignored, so there is no flag, status or interrupt.
- R5: `conv_start` is a one-cycle pulse. It is high in the second cycle after the write that sets `run_en`.
- R6: In single mode (`mode_single`=1), the clock edge that samples `conv_done` high clears `run_en` and sets `done_flag`.
- R7: In repeat mode, `conv_start` pulses again in the cycle after each completion. `run_en` stays 1, and `done_stat` and `done_flag` stay 0.
- R8: `done_flag` stays set until a `flag_rd` pulse clears it. A completion in the same cycle as `flag_rd` leaves the flag set.
- R9: `done_stat` sets on single-mode completion. It keeps its value through `flag_rd` and clears at the edge that ends the next `conv_start` cycle.
- R10: `irq` pulses high for one cycle, in the cycle `done_flag` rises, only when `irq_mask` is 0.
- R11: A host write with `cfg_run`=0 stops the sequence. A completion that arrives two or more cycles later produces no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_run | input | 1 | Run bit being written |
| cfg_single | input | 1 | 1 selects single conversion, 0 selects repeat |
| cfg_temp | input | 1 | Temperature channel enable being written |
| cfg_mask | input | 1 | Interrupt mask being written |
| flag_rd | input | 1 | Host read of the done flag; clears it |
| vbus_ok | input | 1 | Input supply above poor-source level |
| vbat_ok | input | 1 | Battery above low-battery level |
| vbat_regn_ok | input | 1 | Battery above regulator start level |
| conv_done | input | 1 | Converter completion strobe |
| conv_start | output | 1 | Converter start strobe |
| run_en | output | 1 | Run bit readback |
| mode_single | output | 1 | Mode bit readback |
| temp_sel | output | 1 | Temperature channel readback |
| irq_mask | output | 1 | Mask readback |
| done_stat | output | 1 | Live completion status |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt pulse |

## Verification
- A write changes `run_en` one edge later.
- `conv_start` follows one cycle after that, and it drops in the same cycle that supply validity drops.
- A completion strobe changes `run_en`, `done_flag`, `done_stat` and `irq` together at the one edge that samples it.
- In repeat mode, the next start appears in the cycle after that edge.

The bench drives every input on the falling edge and samples outputs on the falling edge that follows the edge of interest. Where the start must be shown suppressed within a cycle, it samples a nanosecond after the drive. The supply sweep covers all 16 combinations of the three comparators and the temperature select. The completion latency is swept from 1 to 4 cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic run;
        logic single;
        logic temp;
        logic mask;
    } seq_cfg_t;

endpackage

// File: rtl/adc_power_gate.sv
module adc_power_gate (
    input  logic vbus_ok,
    input  logic vbat_ok,
    input  logic vbat_regn_ok,
    input  logic temp_sel,
    output logic run_ok
);
    logic batt_path_ok;

    // On battery alone the temperature channel needs the regulator level
    always_comb begin
        batt_path_ok = temp_sel ? vbat_regn_ok : vbat_ok;
        run_ok       = vbus_ok | batt_path_ok;
    end

    always_comb begin
        if (!vbus_ok && !vbat_regn_ok && temp_sel) begin
            p_temp_needs_regn_r3: assert (!run_ok);
        end
    end
endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  seq_cfg_t cfg_in,
    input  logic     run_ok,
    input  logic     single_done,
    output seq_cfg_t cfg_q
);
    seq_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d     = cfg_in;
            cfg_d.run = cfg_in.run & run_ok;
        end else if (!run_ok || single_done) begin
            cfg_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    p_invalid_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !cfg_q.run);
    p_single_clears_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (single_done && !cfg_we) |=> !cfg_q.run);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic run_ok,
    input  logic single,
    input  logic conv_done,
    output logic conv_start,
    output logic launch,
    output logic single_done
);
    seq_state_t state_q, state_d;
    logic go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        go          = run_en & run_ok;
        state_d     = state_q;
        conv_start  = 1'b0;
        launch      = 1'b0;
        single_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                if (go) begin
                    conv_start = 1'b1;
                    launch     = 1'b1;
                    state_d    = ST_CONVERT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_CONVERT: begin
                if (!go) begin
                    state_d = ST_IDLE;
                end else if (conv_done) begin
                    if (single) begin
                        single_done = 1'b1;
                        state_d     = ST_IDLE;
                    end else begin
                        state_d = ST_LAUNCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_start_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(run_en));
endmodule

// File: rtl/adc_done_flags.sv
module adc_done_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic single_done,
    input  logic launch,
    input  logic flag_rd,
    input  logic mask,
    output logic done_stat,
    output logic done_flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_stat <= 1'b0;
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (single_done)  done_stat <= 1'b1;
            else if (launch)  done_stat <= 1'b0;
            if (single_done)  done_flag <= 1'b1;
            else if (flag_rd) done_flag <= 1'b0;
            irq <= single_done & ~done_flag & ~mask;
        end
    end

    p_irq_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $rose(done_flag));
    p_flag_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(single_done));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_run,
    input  logic cfg_single,
    input  logic cfg_temp,
    input  logic cfg_mask,
    input  logic flag_rd,
    input  logic vbus_ok,
    input  logic vbat_ok,
    input  logic vbat_regn_ok,
    input  logic conv_done,
    output logic conv_start,
    output logic run_en,
    output logic mode_single,
    output logic temp_sel,
    output logic irq_mask,
    output logic done_stat,
    output logic done_flag,
    output logic irq
);
    seq_cfg_t cfg_in, cfg_q;
    logic     temp_eff, run_ok, launch, single_done;

    always_comb begin
        cfg_in   = '{run: cfg_run, single: cfg_single, temp: cfg_temp, mask: cfg_mask};
        temp_eff = cfg_we ? cfg_temp : cfg_q.temp;
    end

    adc_power_gate u_gate (
        .vbus_ok      (vbus_ok),
        .vbat_ok      (vbat_ok),
        .vbat_regn_ok (vbat_regn_ok),
        .temp_sel     (temp_eff),
        .run_ok       (run_ok)
    );

    adc_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_in      (cfg_in),
        .run_ok      (run_ok),
        .single_done (single_done),
        .cfg_q       (cfg_q)
    );

    adc_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (cfg_q.run),
        .run_ok      (run_ok),
        .single      (cfg_q.single),
        .conv_done   (conv_done),
        .conv_start  (conv_start),
        .launch      (launch),
        .single_done (single_done)
    );

    adc_done_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .single_done (single_done),
        .launch      (launch),
        .flag_rd     (flag_rd),
        .mask        (cfg_q.mask),
        .done_stat   (done_stat),
        .done_flag   (done_flag),
        .irq         (irq)
    );

    assign run_en      = cfg_q.run;
    assign mode_single = cfg_q.single;
    assign temp_sel    = cfg_q.temp;
    assign irq_mask    = cfg_q.mask;

    p_flag_with_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (single_done && !cfg_we) |=> (done_flag && !run_en));
    p_repeat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_stat) |-> $past(mode_single));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_run = 0, cfg_single = 0, cfg_temp = 0, cfg_mask = 0;
    logic flag_rd = 0, vbus_ok = 0, vbat_ok = 0, vbat_regn_ok = 0, conv_done = 0;
    logic conv_start, run_en, mode_single, temp_sel, irq_mask;
    logic done_stat, done_flag, irq;
    int vectors = 0, fails = 0, starts = 0, cycles = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl uut (.*);

    always @(negedge clk) if (conv_start) starts++;

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic done_summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            done_summary();
        end
    end

    task automatic host_write(input logic r, input logic s, input logic t, input logic m);
        @(negedge clk);
        cfg_run = r; cfg_single = s; cfg_temp = t; cfg_mask = m; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic stop_all();
        host_write(0, 1, 0, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_done();
        conv_done = 1;
        @(negedge clk);
        conv_done = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 run_en", run_en, 0);
        chk("R1 mode", mode_single, 0);
        chk("R1 temp", temp_sel, 0);
        chk("R1 mask", irq_mask, 0);
        chk("R1 stat", done_stat, 0);
        chk("R1 flag", done_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 start", conv_start, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 / R3 sweep of supply comparators and temperature select
        for (int v = 0; v < 16; v++) begin
            logic exp_run;
            vbus_ok = v[0]; vbat_ok = v[1]; vbat_regn_ok = v[2];
            exp_run = v[0] | (v[3] ? v[2] : v[1]);
            host_write(1, 1, v[3], 0);
            if (!v[0] && v[1] && !v[2] && v[3]) chk("R3 temp on battery", run_en, exp_run);
            else chk("R2 write gate", run_en, exp_run);
            chk("R2 temp readback", temp_sel, v[3]);
            stop_all();
        end

        // R5 R6 R9 R10 R8 single conversions, latency 1..4
        vbus_ok = 1; vbat_ok = 0; vbat_regn_ok = 0;
        for (int lat = 1; lat <= 4; lat++) begin
            host_write(1, 1, 0, 0);
            chk("R5 no start yet", conv_start, 0);
            @(negedge clk);
            chk("R5 start pulse", conv_start, 1);
            if (lat > 1) chk("R9 stat held until start ends", done_stat, 1);
            repeat (lat) @(negedge clk);
            chk("R5 start one cycle", conv_start, 0);
            chk("R9 stat cleared after start", done_stat, 0);
            chk("R6 run before done", run_en, 1);
            pulse_done();
            chk("R6 run cleared", run_en, 0);
            chk("R6 flag set", done_flag, 1);
            chk("R9 stat set", done_stat, 1);
            chk("R10 irq pulse", irq, 1);
            @(negedge clk);
            chk("R10 irq one cycle", irq, 0);
            chk("R8 flag sticky", done_flag, 1);
            flag_rd = 1;
            @(negedge clk);
            flag_rd = 0;
            chk("R8 flag cleared by read", done_flag, 0);
            chk("R9 stat survives read", done_stat, 1);
        end

        // R10 masked and R8 read colliding with completion
        host_write(1, 1, 0, 1);
        repeat (2) @(negedge clk);
        flag_rd = 1;
        pulse_done();
        flag_rd = 0;
        chk("R8 set wins over read", done_flag, 1);
        chk("R10 masked irq", irq, 0);
        flag_rd = 1; @(negedge clk); flag_rd = 0;

        // R7 repeat mode
        starts = 0;
        host_write(1, 0, 0, 0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            pulse_done();
            chk("R7 restart after done", conv_start, 1);
            chk("R7 run stays", run_en, 1);
            chk("R7 flag quiet", done_flag, 0);
            chk("R7 stat quiet", done_stat, 0);
            @(negedge clk);
        end
        chk("R7 start count", starts == 4, 1);

        // R11 host stop, then a late completion
        host_write(0, 0, 0, 0);
        @(negedge clk);
        host_write(0, 1, 0, 0);
        @(negedge clk);
        pulse_done();
        chk("R11 no flag after stop", done_flag, 0);
        chk("R11 run off", run_en, 0);

        // R4 supply loss mid-conversion
        host_write(1, 1, 0, 0);
        repeat (2) @(negedge clk);
        vbus_ok = 0;
        @(negedge clk);
        chk("R4 run cleared on loss", run_en, 0);
        vbus_ok = 1;
        pulse_done();
        chk("R4 no flag after abort", done_flag, 0);
        chk("R4 no irq after abort", irq, 0);
        repeat (2) @(negedge clk);
        chk("R4 no restart", conv_start, 0);

        // R4 start suppressed within the launch cycle
        host_write(1, 1, 0, 0);
        @(negedge clk);
        vbus_ok = 0;
        #1;
        chk("R4 start suppressed", conv_start, 0);
        @(negedge clk);
        chk("R4 run cleared", run_en, 0);
        repeat (3) @(negedge clk);
        done_summary();
    end
endmodule